// File: doc/BRIEF.md
# Thread-Filtered Event Counter Unit

This block counts hardware events for a multithreaded processor core. It holds two general event counters and one free-running cycle counter, and software reaches all of them through a small single-cycle register bus. Each general counter packs its event code, a per-thread enable mask and a 24-bit count into one 32-bit word. A counter is running whenever the top byte of that word is nonzero. Clearing the top byte stops it and keeps the count.

Event sources sit outside the block. Thread-tagged sources arrive as one pulse per event code, each with the number of the thread that raised it. Two further sets of untagged pulses, core-internal and channel events, are chosen per counter through small sub-select registers. A count that rolls over sets a sticky overflow flag, and that flag drives the counter's interrupt line. Software preloads the count with minus the sampling period to schedule the next overflow. A build-time legacy option models older cores: it has no overflow flags, and any write to a counter word zeroes its count.

Top module: `evc_unit`

## Requirements
- R1: After reset every counter word, sub-select register, the cycle counter, the overflow flags, both interrupt outputs and the read data are zero, so both general counters are stopped.
- R2: Reads return data one cycle after the request. The word map is: 0 counter 0, 1 counter 1, 2 and 3 the core-internal sub-selects of counters 0 and 1, 4 and 5 their channel sub-selects, 6 the cycle counter, 7 the overflow status. Sub-selects read zero-extended 4-bit values. Any other address reads zero.
- R3: A counter word holds the event code in bits 31:28, the thread mask in bits 27:24 and the count in bits 23:0. For a thread-filtered code, the count rises by one in each cycle where that code's pulse is high and the mask bit indexed by the pulse's thread number is set. If that mask bit is clear, the count does not change.
- R4: Codes marked global (by default codes 8 and 9) count every pulse of their source, whatever the thread mask holds.
- R5: Code 0xD counts the core-internal pulse picked by the counter's core sub-select. Code 0xF counts the channel pulse picked by its channel sub-select.
- R6: Writing zero to bits 31:24 stops counting and keeps the count. Writing a nonzero top byte with the same low bits resumes counting from the kept value.
- R7: The count wraps modulo 2^24. A roll from 0xFFFFFF to 0 sets the overflow flag of that counter, which reads in status bit 16 for counter 0 and bit 17 for counter 1. Each interrupt output equals its flag.
- R8: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged. A roll-over in the same cycle as the clear leaves the flag set.
- R9: When a write to a counter word and a counted event fall in the same cycle, the written value is kept and the event is lost.
- R10: The 32-bit cycle counter rises by one in each clock where the active-thread input is high. Any write to it zeroes it, whatever the data.
- R11: In legacy mode a write to a counter word loads only its top byte and zeroes its count, and the overflow flags and interrupts stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one cycle after a read |
| ev_hit | input | 16 | One pulse per thread-tagged event code |
| ev_tid | input | 32 | Thread number of each pulse, 2 bits per code, code n at bits 2n+1:2n |
| core_ev | input | 16 | Untagged core-internal event pulses |
| chan_ev | input | 16 | Untagged channel event pulses |
| thr_run | input | 1 | Active thread is running this clock |
| irq_ctr0 | output | 1 | Overflow interrupt of counter 0 |
| irq_ctr1 | output | 1 | Overflow interrupt of counter 1 |

## Verification
The assertions rely on the register bus being the only way to change a counter word, and on the active-thread and event inputs being clean levels sampled at the clock. On that basis, a count can move by at most one per cycle, and a flag can only rise right after its count read 0xFFFFFF. The stimulus drives every input half a cycle away from the sampling edge. Its random phase mixes reads, writes and event pulses freely, including writes to the status and counter words in the same cycles as events, so the write-wins and set-beats-clear orderings are reached.

// File: rtl/evc_pkg.sv
package evc_pkg;
  // word addresses of the register map
  localparam int unsigned A_CTR0  = 0;
  localparam int unsigned A_CSEL0 = 2;
  localparam int unsigned A_HSEL0 = 4;
  localparam int unsigned A_CYC   = 6;
  localparam int unsigned A_STAT  = 7;
  // event codes that redirect to sub-selected sources
  localparam logic [3:0] CODE_CORE = 4'hD;
  localparam logic [3:0] CODE_CHAN = 4'hF;
  // status bit of counter 0; counter i uses STAT_LSB + i
  localparam int unsigned STAT_LSB = 16;
endpackage

// File: rtl/evc_event_sel.sv
module evc_event_sel #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned SUB_W       = 4,
  parameter logic [(1<<CODE_W)-1:0] GLOBAL_MASK = '0,
  localparam int unsigned NUM_CODES  = 1 << CODE_W,
  localparam int unsigned NUM_SUB    = 1 << SUB_W,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [CODE_W-1:0]          code,
  input  logic [NUM_THREADS-1:0]     tmask,
  input  logic [SUB_W-1:0]           core_sel,
  input  logic [SUB_W-1:0]           chan_sel,
  input  logic [NUM_CODES-1:0]       ev_hit,
  input  logic [NUM_CODES*TID_W-1:0] ev_tid,
  input  logic [NUM_SUB-1:0]         core_ev,
  input  logic [NUM_SUB-1:0]         chan_ev,
  output logic                       hit
);
  import evc_pkg::*;

  logic [TID_W-1:0] tid;

  always_comb begin
    tid = ev_tid[int'(code)*TID_W +: TID_W];
    if (code == CODE_W'(CODE_CORE)) begin
      hit = core_ev[core_sel];
    end else if (code == CODE_W'(CODE_CHAN)) begin
      hit = chan_ev[chan_sel];
    end else begin
      hit = ev_hit[code] && (GLOBAL_MASK[code] || tmask[tid]);
    end
  end
endmodule

// File: rtl/evc_gen_ctr.sv
module evc_gen_ctr #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned TOP_W  = 8,
  parameter bit          LEGACY = 1'b0,
  localparam int unsigned WORD_W = CNT_W + TOP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              hit,
  output logic [WORD_W-1:0] word_q,
  output logic              wrap
);
  logic             running;
  logic [CNT_W-1:0] count;
  logic             bump;

  assign running = |word_q[WORD_W-1:CNT_W];
  assign count   = word_q[CNT_W-1:0];
  assign bump    = !wr && running && hit;

  generate
    if (LEGACY) begin : g_leg
      assign wrap = 1'b0;
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q <= '0;
        end else if (wr) begin
          word_q <= {wdata[WORD_W-1:CNT_W], {CNT_W{1'b0}}};
        end else if (bump) begin
          word_q[CNT_W-1:0] <= count + 1'b1;
        end
      end
    end else begin : g_ovf
      assign wrap = bump && (&count);
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q <= '0;
        end else if (wr) begin
          word_q <= wdata;
        end else if (bump) begin
          word_q[CNT_W-1:0] <= count + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/evc_cycle_ctr.sv
module evc_cycle_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (run) begin
      q <= q + 1'b1;
    end
  end
endmodule

// File: rtl/evc_ovf_status.sv
module evc_ovf_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          flag[i] <= 1'b0;
        end else if (set[i]) begin
          flag[i] <= 1'b1;
        end else if (clr[i]) begin
          flag[i] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/evc_unit.sv
module evc_unit #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned SUB_W       = 4,
  parameter int unsigned CYC_W       = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter logic [(1<<CODE_W)-1:0] GLOBAL_MASK = 16'h0300,
  parameter bit          LEGACY      = 1'b0,
  localparam int unsigned TOP_W      = CODE_W + NUM_THREADS,
  localparam int unsigned DATA_W     = TOP_W + CNT_W,
  localparam int unsigned NUM_CODES  = 1 << CODE_W,
  localparam int unsigned NUM_SUB    = 1 << SUB_W,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_CODES-1:0]       ev_hit,
  input  logic [NUM_CODES*TID_W-1:0] ev_tid,
  input  logic [NUM_SUB-1:0]         core_ev,
  input  logic [NUM_SUB-1:0]         chan_ev,
  input  logic                       thr_run,
  output logic                       irq_ctr0,
  output logic                       irq_ctr1
);
  import evc_pkg::*;

  localparam int unsigned NUM_CTR = 2;

  logic              wr_any;
  logic [DATA_W-1:0] ctr_q    [NUM_CTR];
  logic [SUB_W-1:0]  core_sel [NUM_CTR];
  logic [SUB_W-1:0]  chan_sel [NUM_CTR];
  logic [NUM_CTR-1:0] ctr_hit, ctr_wrap, stat_clr, ovf_flag;
  logic [CYC_W-1:0]  cyc_q;
  logic [DATA_W-1:0] rd_next;

  assign wr_any = bus_valid && bus_write;

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic wr_ctr, wr_core, wr_chan;
      assign wr_ctr  = wr_any && (bus_addr == ADDR_W'(A_CTR0 + i));
      assign wr_core = wr_any && (bus_addr == ADDR_W'(A_CSEL0 + i));
      assign wr_chan = wr_any && (bus_addr == ADDR_W'(A_HSEL0 + i));
      assign stat_clr[i] = wr_any && (bus_addr == ADDR_W'(A_STAT))
                           && bus_wdata[STAT_LSB + i];

      always_ff @(posedge clk) begin
        if (rst) begin
          core_sel[i] <= '0;
          chan_sel[i] <= '0;
        end else begin
          if (wr_core) core_sel[i] <= bus_wdata[SUB_W-1:0];
          if (wr_chan) chan_sel[i] <= bus_wdata[SUB_W-1:0];
        end
      end

      evc_event_sel #(
        .NUM_THREADS (NUM_THREADS),
        .CODE_W      (CODE_W),
        .SUB_W       (SUB_W),
        .GLOBAL_MASK (GLOBAL_MASK)
      ) u_sel (
        .code     (ctr_q[i][DATA_W-1 -: CODE_W]),
        .tmask    (ctr_q[i][CNT_W +: NUM_THREADS]),
        .core_sel (core_sel[i]),
        .chan_sel (chan_sel[i]),
        .ev_hit   (ev_hit),
        .ev_tid   (ev_tid),
        .core_ev  (core_ev),
        .chan_ev  (chan_ev),
        .hit      (ctr_hit[i])
      );

      evc_gen_ctr #(
        .CNT_W  (CNT_W),
        .TOP_W  (TOP_W),
        .LEGACY (LEGACY)
      ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_ctr),
        .wdata  (bus_wdata),
        .hit    (ctr_hit[i]),
        .word_q (ctr_q[i]),
        .wrap   (ctr_wrap[i])
      );
    end
  endgenerate

  evc_ovf_status #(.N(NUM_CTR)) u_stat (
    .clk  (clk),
    .rst  (rst),
    .set  (ctr_wrap),
    .clr  (stat_clr),
    .flag (ovf_flag)
  );

  evc_cycle_ctr #(.W(CYC_W)) u_cyc (
    .clk (clk),
    .rst (rst),
    .clr (wr_any && (bus_addr == ADDR_W'(A_CYC))),
    .run (thr_run),
    .q   (cyc_q)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (bus_addr == ADDR_W'(A_CTR0 + i))  rd_next = ctr_q[i];
      if (bus_addr == ADDR_W'(A_CSEL0 + i)) rd_next = DATA_W'(core_sel[i]);
      if (bus_addr == ADDR_W'(A_HSEL0 + i)) rd_next = DATA_W'(chan_sel[i]);
    end
    if (bus_addr == ADDR_W'(A_CYC)) rd_next = DATA_W'(cyc_q);
    if (bus_addr == ADDR_W'(A_STAT)) begin
      for (int i = 0; i < NUM_CTR; i++) rd_next[STAT_LSB + i] = ovf_flag[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_valid && !bus_write) begin
      bus_rdata <= rd_next;
    end
  end

  assign irq_ctr0 = ovf_flag[0];
  assign irq_ctr1 = ovf_flag[1];
endmodule

// File: rtl/evc_unit_chk.sv
module evc_unit_chk #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CYC_W  = 32,
  parameter int unsigned ADDR_W = 4,
  parameter bit          LEGACY = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              thr_run,
  input logic [DATA_W-1:0] ctr0_q,
  input logic [DATA_W-1:0] ctr1_q,
  input logic [CYC_W-1:0]  cyc_q,
  input logic              irq_ctr0,
  input logic              irq_ctr1
);
  logic wr0, wr1, wrc, clr0, clr1;
  logic [CNT_W-1:0] c0, c1;

  assign wr0  = bus_valid && bus_write && (bus_addr == ADDR_W'(0));
  assign wr1  = bus_valid && bus_write && (bus_addr == ADDR_W'(1));
  assign wrc  = bus_valid && bus_write && (bus_addr == ADDR_W'(6));
  assign clr0 = bus_valid && bus_write && (bus_addr == ADDR_W'(7)) && bus_wdata[16];
  assign clr1 = bus_valid && bus_write && (bus_addr == ADDR_W'(7)) && bus_wdata[17];
  assign c0   = ctr0_q[CNT_W-1:0];
  assign c1   = ctr1_q[CNT_W-1:0];

  // R3: without a write a count moves by at most one per cycle
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    !wr0 |=> (c0 == $past(c0)) || (c0 == ($past(c0) + 1'b1)));
  p_step1_r3: assert property (@(posedge clk) disable iff (rst)
    !wr1 |=> (c1 == $past(c1)) || (c1 == ($past(c1) + 1'b1)));

  // R6: a stopped counter keeps its whole word
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ctr0_q[DATA_W-1:CNT_W] == '0) && !wr0 |=> $stable(ctr0_q));

  // R7: a flag rises only after the count sat at its maximum
  p_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ctr0) |-> ($past(c0) == {CNT_W{1'b1}}));
  p_rise1_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ctr1) |-> ($past(c1) == {CNT_W{1'b1}}));

  // R8: flags are sticky until written with 1
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    irq_ctr0 && !clr0 |=> irq_ctr0);
  p_sticky1_r8: assert property (@(posedge clk) disable iff (rst)
    irq_ctr1 && !clr1 |=> irq_ctr1);

  // R9 / R11: a write decides the next count
  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> (c0 == ((LEGACY != 0) ? '0 : $past(bus_wdata[CNT_W-1:0]))));

  // R10: cycle counter steps or clears
  p_cyc_step_r10: assert property (@(posedge clk) disable iff (rst)
    !wrc && thr_run |=> (cyc_q == ($past(cyc_q) + 1'b1)));
  p_cyc_clr_r10: assert property (@(posedge clk) disable iff (rst)
    wrc |=> (cyc_q == '0));

  // R11: legacy build never raises an interrupt
  p_legacy_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (LEGACY != 0) |-> (!irq_ctr0 && !irq_ctr1));
endmodule

bind evc_unit evc_unit_chk #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .CYC_W  (CYC_W),
  .ADDR_W (ADDR_W),
  .LEGACY (LEGACY)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .thr_run   (thr_run),
  .ctr0_q    (ctr_q[0]),
  .ctr1_q    (ctr_q[1]),
  .cyc_q     (cyc_q),
  .irq_ctr0  (irq_ctr0),
  .irq_ctr1  (irq_ctr1)
);

// File: tb/evc_unit_test.sv
module evc_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        bv = 0, bw = 0;
  logic [3:0]  ba = 0;
  logic [31:0] bwd = 0;
  logic [15:0] ev_hit = 0, core_ev = 0, chan_ev = 0;
  logic [31:0] ev_tid = 0;
  logic        thr_run = 0;

  logic [31:0] dut_rd  [2];
  logic        dut_irq [2][2];

  evc_unit #(.LEGACY(1'b0)) uut (
    .clk(clk), .rst(rst), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
    .bus_wdata(bwd), .bus_rdata(dut_rd[0]), .ev_hit(ev_hit), .ev_tid(ev_tid),
    .core_ev(core_ev), .chan_ev(chan_ev), .thr_run(thr_run),
    .irq_ctr0(dut_irq[0][0]), .irq_ctr1(dut_irq[0][1]));

  evc_unit #(.LEGACY(1'b1)) uut_leg (
    .clk(clk), .rst(rst), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
    .bus_wdata(bwd), .bus_rdata(dut_rd[1]), .ev_hit(ev_hit), .ev_tid(ev_tid),
    .core_ev(core_ev), .chan_ev(chan_ev), .thr_run(thr_run),
    .irq_ctr0(dut_irq[1][0]), .irq_ctr1(dut_irq[1][1]));

  int checks = 0, errors = 0;
  string tag = "R1";
  bit started = 0;

  // ---------------- behavioural reference (instance 1 is legacy) ----------
  logic [23:0] m_cnt [2][2];
  logic [7:0]  m_top [2][2];
  logic [3:0]  m_core[2][2], m_chan[2][2];
  logic [31:0] m_cyc [2];
  logic        m_st  [2][2];
  logic [31:0] m_rd  [2];

  function automatic logic [31:0] m_read(int k, int a);
    case (a)
      0, 1:    return {m_top[k][a], m_cnt[k][a]};
      2, 3:    return {28'd0, m_core[k][a-2]};
      4, 5:    return {28'd0, m_chan[k][a-4]};
      6:       return m_cyc[k];
      7:       return {14'd0, m_st[k][1], m_st[k][0], 16'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit m_event(int k, int c);
    int code = int'(m_top[k][c][7:4]);
    int thr  = int'(ev_tid[code*2 +: 2]);
    if (code == 13) return core_ev[m_core[k][c]];
    if (code == 15) return chan_ev[m_chan[k][c]];
    if (code == 8 || code == 9) return ev_hit[code];
    return ev_hit[code] && m_top[k][c][thr];
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        for (int c = 0; c < 2; c++) begin
          m_cnt[k][c] = 0; m_top[k][c] = 0; m_core[k][c] = 0;
          m_chan[k][c] = 0; m_st[k][c] = 0;
        end
        m_cyc[k] = 0; m_rd[k] = 0;
      end else begin
        bit wrap [2];
        bit hitv [2];
        if (bv && !bw) m_rd[k] = m_read(k, int'(ba));
        for (int c = 0; c < 2; c++) hitv[c] = m_event(k, c);
        for (int c = 0; c < 2; c++) begin
          wrap[c] = 0;
          if (bv && bw && int'(ba) == c) begin
            m_top[k][c] = bwd[31:24];
            m_cnt[k][c] = (k == 1) ? 24'd0 : bwd[23:0];
          end else if (m_top[k][c] != 0 && hitv[c]) begin
            if (m_cnt[k][c] == 24'hFFFFFF) wrap[c] = (k == 0);
            m_cnt[k][c] = m_cnt[k][c] + 24'd1;
          end
          if (bv && bw && int'(ba) == 2 + c) m_core[k][c] = bwd[3:0];
          if (bv && bw && int'(ba) == 4 + c) m_chan[k][c] = bwd[3:0];
          if (bv && bw && ba == 4'd7 && bwd[16+c]) m_st[k][c] = 0;
          if (wrap[c]) m_st[k][c] = 1;
        end
        if (bv && bw && ba == 4'd6) m_cyc[k] = 0;
        else if (thr_run) m_cyc[k] = m_cyc[k] + 1;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      for (int k = 0; k < 2; k++) begin
        checks++;
        if (dut_rd[k] !== m_rd[k]) begin
          errors++;
          $display("FAIL %s inst%0d rdata act=%h exp=%h", tag, k, dut_rd[k], m_rd[k]);
        end
        for (int c = 0; c < 2; c++) begin
          checks++;
          if (dut_irq[k][c] !== m_st[k][c]) begin
            errors++;
            $display("FAIL %s inst%0d irq%0d act=%0b exp=%0b", tag, k, c,
                     dut_irq[k][c], m_st[k][c]);
          end
        end
      end
    end
  end

  // ---------------- stimulus helpers (start and end at a negedge) ---------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bv = 1; bw = 1; ba = a; bwd = d;
    @(negedge clk);
    bv = 0; bw = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    bv = 1; bw = 0; ba = a;
    @(negedge clk);
    bv = 0;
  endtask

  task automatic expect_rd(input string t, input int k, input logic [31:0] exp);
    checks++;
    if (dut_rd[k] !== exp) begin
      errors++;
      $display("FAIL %s inst%0d read act=%h exp=%h", t, k, dut_rd[k], exp);
    end
  endtask

  task automatic expect_bit(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", t, act, exp);
    end
  endtask

  task automatic pulse(input int code, input int thr, input int n);
    ev_hit[code] = 1; ev_tid[code*2 +: 2] = 2'(thr);
    repeat (n) @(negedge clk);
    ev_hit[code] = 0;
  endtask

  // ---------------- watchdog ----------------
  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;

    // R1: reset state
    tag = "R1";
    for (int a = 0; a < 8; a++) begin
      rd(4'(a));
      expect_rd("R1 reset", 0, 32'd0);
    end
    expect_bit("R1 irq0", dut_irq[0][0], 1'b0);

    // R3: thread filtering on code 0, mask = thread 1
    tag = "R3";
    wr(4'd0, 32'h0200_0010);
    pulse(0, 1, 5);
    pulse(0, 2, 3);
    rd(4'd0);
    expect_rd("R3 filtered count", 0, 32'h0200_0015);
    expect_rd("R11 legacy cleared count", 1, 32'h0200_0005);

    // R4: global code 8 with empty mask
    tag = "R4";
    wr(4'd1, 32'h8000_0000);
    pulse(8, 3, 4);
    rd(4'd1);
    expect_rd("R4 global code", 0, 32'h8000_0004);

    // R5: sub-selected sources
    tag = "R5";
    wr(4'd2, 32'd5);
    wr(4'd0, 32'hD100_0000);
    core_ev[5] = 1; repeat (3) @(negedge clk); core_ev[5] = 0;
    core_ev[4] = 1; repeat (2) @(negedge clk); core_ev[4] = 0;
    rd(4'd0);
    expect_rd("R5 core sub-select", 0, 32'hD100_0003);
    wr(4'd5, 32'd2);
    wr(4'd1, 32'hF100_0000);
    chan_ev[2] = 1; repeat (2) @(negedge clk); chan_ev[2] = 0;
    chan_ev[1] = 1; repeat (2) @(negedge clk); chan_ev[1] = 0;
    rd(4'd1);
    expect_rd("R5 channel sub-select", 0, 32'hF100_0002);

    // R2: sub-select readback and unmapped address
    tag = "R2";
    rd(4'd2);
    expect_rd("R2 sub-select read", 0, 32'd5);
    rd(4'd9);
    expect_rd("R2 unmapped read", 0, 32'd0);

    // R6: stop keeps count, restart resumes
    tag = "R6";
    wr(4'd0, 32'h0000_0003);
    core_ev[5] = 1; repeat (4) @(negedge clk); core_ev[5] = 0;
    rd(4'd0);
    expect_rd("R6 stopped hold", 0, 32'h0000_0003);
    wr(4'd0, 32'hD100_0003);
    core_ev[5] = 1; repeat (2) @(negedge clk); core_ev[5] = 0;
    rd(4'd0);
    expect_rd("R6 resumed", 0, 32'hD100_0005);

    // R7: wrap sets flag 16
    tag = "R7";
    wr(4'd0, 32'h01FF_FFFD);
    pulse(0, 0, 5);
    rd(4'd0);
    expect_rd("R7 wrapped count", 0, 32'h0100_0002);
    expect_bit("R7 irq0 set", dut_irq[0][0], 1'b1);
    expect_bit("R11 legacy irq0", dut_irq[1][0], 1'b0);

    // R8: write-one-to-clear, set beats clear
    tag = "R8";
    wr(4'd7, 32'h0002_0000);
    expect_bit("R8 zero bit no effect", dut_irq[0][0], 1'b1);
    rd(4'd7);
    expect_rd("R8 status read", 0, 32'h0001_0000);
    wr(4'd7, 32'h0001_0000);
    expect_bit("R8 cleared", dut_irq[0][0], 1'b0);
    wr(4'd0, 32'h01FF_FFFF);
    ev_hit[0] = 1; ev_tid[1:0] = 2'd0;
    wr(4'd7, 32'h0001_0000);
    ev_hit[0] = 0;
    expect_bit("R8 set beats clear", dut_irq[0][0], 1'b1);
    wr(4'd7, 32'h0003_0000);

    // R9: write wins over same-cycle event
    tag = "R9";
    ev_hit[0] = 1; ev_tid[1:0] = 2'd0;
    wr(4'd0, 32'h0100_0100);
    ev_hit[0] = 0;
    rd(4'd0);
    expect_rd("R9 write wins", 0, 32'h0100_0100);
    expect_rd("R11 legacy write", 1, 32'h0100_0000);

    // R10: cycle counter
    tag = "R10";
    wr(4'd6, 32'hFFFF_FFFF);
    thr_run = 1; repeat (10) @(negedge clk); thr_run = 0;
    rd(4'd6);
    expect_rd("R10 cycle count", 0, 32'd10);

    // random mix, R3 R7 R8 R9 R10 R11 against the reference
    tag = "R9 random";
    for (int i = 0; i < 4000; i++) begin
      bv = ($urandom % 3) != 0; bw = $urandom % 2;
      ba = 4'($urandom % 10);
      bwd = $urandom;
      if ($urandom % 2) bwd[23:0] = 24'hFFFFF0 | 24'($urandom % 16);
      ev_hit = 16'($urandom); ev_tid = $urandom;
      core_ev = 16'($urandom); chan_ev = 16'($urandom);
      thr_run = $urandom % 2;
      @(negedge clk);
    end
    bv = 0; ev_hit = 0; core_ev = 0; chan_ev = 0; thr_run = 0;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule